// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Sensing

This block is a bank of 32 general-purpose pins placed behind a plain 32-bit register bus. Every pin is either a general pin, whose direction and output level are set by registers, or an interrupt input. For interrupt inputs, software chooses per pin whether a level or an edge is sensed, which polarity counts as active, and whether both edges are taken regardless of polarity.

Pin inputs are synchronised through two flops before any use. Edge events are latched into a status register until software clears them with a write-one-to-clear register. Level-sensed pins show their polarity-adjusted level in the status register without latching. Enables are changed through two registers: one that can only drop enable bits and one that can only raise them. A single interrupt output is high while any enabled pin has its status bit set. Software reads status, picks the lowest set pin, clears it and repeats.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every register reads 0, `pin_oe` is 0, `pin_out` is 0 and `irq_out` is 0.
- R2: Byte offsets 0x00 (mode), 0x04 (direction), 0x08 (output data), 0x20 (polarity), 0x24 (edge select), 0x28 (filter enable) and 0x4C (both-edge) read back the value last written. The clear (0x14) and unmask (0x1C) offsets read 0. Any unmapped offset reads 0 and ignores writes.
- R3: `pin_oe[i]` equals direction bit i (1 = output) while mode bit i is 0 (general pin), and is 0 while mode bit i is 1 (interrupt input). `pin_out` equals the output-data register.
- R4: Offset 0x0C reads the pin levels after a two-flop synchroniser: a pin change driven before clock edge k is visible after edge k+1 and not after edge k.
- R5: For a pin with mode=1 and edge-select bit (0x24) = 1, a latched status bit (read at 0x10) is set three clock edges after the pin change. With both-edge bit (0x4C) = 0, polarity bit (0x20) = 0 selects the rising edge and polarity = 1 selects the falling edge. With both-edge = 1, both edges count whatever the polarity.
- R6: For a pin with mode=1 and edge-select = 0, the status bit equals the synchronised pin level XOR its polarity bit, and it is not latched.
- R7: A pin with mode=0 always has status 0.
- R8: Writing 1 to a bit of offset 0x14 clears that pin's latched edge status. Bits written as 0 leave status unchanged.
- R9: If a clear write and a new edge event on the same pin fall in the same cycle, the status bit stays 1.
- R10: Offset 0x18 reads the enable bits. Writing 0x18 clears each enable bit written as 0 and keeps each written as 1. Writing 1 to a bit of 0x1C sets that enable bit.
- R11: `irq_out` is 1 exactly when some pin has both its status bit and its enable bit set.
- R12: The filter-enable register has no effect on sensing or status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| pin_in | input | NPINS | Asynchronous pin levels |
| pin_out | output | NPINS | Output levels |
| pin_oe | output | NPINS | Output driver enables |
| irq_out | output | 1 | Combined interrupt request |

## Verification
A fixed configuration covers every sense mode at once. The low eight pins are general pins. Each of the remaining pins takes its polarity, edge-select and both-edge bits from its own index, so every combination appears on several pins. The bench drives all-zero, all-one and alternating vectors, then a pseudo-random sequence. Rising-only, falling-only and both-edge pins latch differently on the same vector, and level pins follow the pin, so one wrong select path or one wrong polarity shows up as a mismatch against the arithmetic model. Partial clear masks separate cleared pins from untouched ones. A clear timed into the exact event cycle tells the intended priority from the reverse one. Mask and unmask writes with single-bit patterns show that each register affects only its own direction of change.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFF_MODE   = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_DIR    = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_DOUT   = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_DIN    = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_STAT   = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_CLR    = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_MASK   = 8'h18;
    localparam logic [ADDR_W-1:0] OFF_UNMASK = 8'h1C;
    localparam logic [ADDR_W-1:0] OFF_POL    = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_EDGE   = 8'h24;
    localparam logic [ADDR_W-1:0] OFF_FILT   = 8'h28;
    localparam logic [ADDR_W-1:0] OFF_BOTH   = 8'h4C;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_MODE, SEL_DIR, SEL_DOUT, SEL_DIN, SEL_STAT, SEL_CLR,
        SEL_MASK, SEL_UNMASK, SEL_POL, SEL_EDGE, SEL_FILT, SEL_BOTH
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFF_MODE:   s = SEL_MODE;
            OFF_DIR:    s = SEL_DIR;
            OFF_DOUT:   s = SEL_DOUT;
            OFF_DIN:    s = SEL_DIN;
            OFF_STAT:   s = SEL_STAT;
            OFF_CLR:    s = SEL_CLR;
            OFF_MASK:   s = SEL_MASK;
            OFF_UNMASK: s = SEL_UNMASK;
            OFF_POL:    s = SEL_POL;
            OFF_EDGE:   s = SEL_EDGE;
            OFF_FILT:   s = SEL_FILT;
            OFF_BOTH:   s = SEL_BOTH;
            default:    s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] lvl,
    output logic [W-1:0] prev
);

    // chain[0] is the first flop; chain[STAGES-1] is the synchronised level,
    // chain[STAGES] holds the sample before it for edge comparison.
    typedef struct packed {
        logic [STAGES:0][W-1:0] chain;
    } sync_st_t;

    sync_st_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[STAGES-1:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign lvl  = s_q.chain[STAGES-1];
    assign prev = s_q.chain[STAGES];

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] prev,
    input  logic [W-1:0] mode,
    input  logic [W-1:0] pol,
    input  logic [W-1:0] edg,
    input  logic [W-1:0] both,
    input  logic         clr_we,
    input  logic         msk_we,
    input  logic         unmsk_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] stat,
    output logic [W-1:0] en,
    output logic         irq
);

    typedef struct packed {
        logic [W-1:0] stat;
        logic [W-1:0] en;
    } irq_st_t;

    irq_st_t      r_d, r_q;
    logic [W-1:0] evt;
    logic [W-1:0] lvl_on;
    logic [W-1:0] latch_pin;

    // Per-pin event and level sense
    for (genvar i = 0; i < W; i++) begin : g_pin
        logic rise, fall, hit;
        assign rise      = lvl[i] & ~prev[i];
        assign fall      = ~lvl[i] & prev[i];
        assign hit       = both[i] ? (rise | fall) : (pol[i] ? fall : rise);
        assign latch_pin[i] = mode[i] & edg[i];
        assign evt[i]    = latch_pin[i] & hit;
        assign lvl_on[i] = mode[i] & ~edg[i] & (lvl[i] ^ pol[i]);
    end

    always_comb begin
        logic [W-1:0] clr;
        r_d  = r_q;
        clr  = clr_we ? wdata : '0;
        // a new event overrides a clear in the same cycle
        r_d.stat = (((r_q.stat & ~clr) | evt) & latch_pin) | lvl_on;
        if (msk_we)   r_d.en = r_q.en & wdata;
        if (unmsk_we) r_d.en = r_q.en | wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign stat = r_q.stat;
    assign en   = r_q.en;
    assign irq  = |(r_q.stat & r_q.en);

    // R5: every detected event shows up in status on the next cycle
    p_edge_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((stat & $past(evt)) == $past(evt)));

    // R9: a clear landing together with an event loses
    p_edge_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && ((evt & wdata) != '0)) |=>
        ((stat & $past(evt & wdata)) == $past(evt & wdata)));

    // R8: cleared edge pins without a new event drop to 0
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((stat & $past(wdata & latch_pin & ~evt)) == '0));

    // R6: level pins mirror the adjusted level one cycle later
    p_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((stat ^ $past(lvl ^ pol)) & $past(mode & ~edg)) == '0));

    // R7: general pins never carry status
    p_mode_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat & ~$past(mode)) == '0));

    // R10: mask write only drops bits written as 0
    p_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        msk_we |=> ((en & ~$past(wdata)) == '0) && ((en ^ $past(en)) & $past(wdata)) == '0);

    // R10: unmask write raises every bit written as 1
    p_unmask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        unmsk_we |=> ((en & $past(wdata)) == $past(wdata)));

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_we,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [BUS_W-1:0]      bus_wdata,
    output logic [BUS_W-1:0]      bus_rdata,
    input  logic [NPINS-1:0]      pin_in,
    output logic [NPINS-1:0]      pin_out,
    output logic [NPINS-1:0]      pin_oe,
    output logic                  irq_out
);

    localparam int SYNC_STAGES = 2;

    typedef struct packed {
        logic [NPINS-1:0] mode;
        logic [NPINS-1:0] dir;
        logic [NPINS-1:0] dout;
        logic [NPINS-1:0] pol;
        logic [NPINS-1:0] edg;
        logic [NPINS-1:0] both;
        logic [NPINS-1:0] filt;
    } cfg_st_t;

    cfg_st_t          c_d, c_q;
    reg_sel_e         sel;
    logic             wr_en;
    logic [NPINS-1:0] wpins;
    logic [NPINS-1:0] lvl, prev;
    logic [NPINS-1:0] stat, en;
    logic [NPINS-1:0] rd_pins;

    assign sel   = decode_addr(bus_addr);
    assign wr_en = bus_sel & bus_we;
    assign wpins = bus_wdata[NPINS-1:0];

    gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pin_in),
        .lvl  (lvl),
        .prev (prev)
    );

    gpio_irq_unit #(.W(NPINS)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl     (lvl),
        .prev    (prev),
        .mode    (c_q.mode),
        .pol     (c_q.pol),
        .edg     (c_q.edg),
        .both    (c_q.both),
        .clr_we  (wr_en && sel == SEL_CLR),
        .msk_we  (wr_en && sel == SEL_MASK),
        .unmsk_we(wr_en && sel == SEL_UNMASK),
        .wdata   (wpins),
        .stat    (stat),
        .en      (en),
        .irq     (irq_out)
    );

    always_comb begin
        c_d = c_q;
        if (wr_en) begin
            case (sel)
                SEL_MODE: c_d.mode = wpins;
                SEL_DIR:  c_d.dir  = wpins;
                SEL_DOUT: c_d.dout = wpins;
                SEL_POL:  c_d.pol  = wpins;
                SEL_EDGE: c_d.edg  = wpins;
                SEL_BOTH: c_d.both = wpins;
                SEL_FILT: c_d.filt = wpins;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    always_comb begin
        case (sel)
            SEL_MODE: rd_pins = c_q.mode;
            SEL_DIR:  rd_pins = c_q.dir;
            SEL_DOUT: rd_pins = c_q.dout;
            SEL_DIN:  rd_pins = lvl;
            SEL_STAT: rd_pins = stat;
            SEL_MASK: rd_pins = en;
            SEL_POL:  rd_pins = c_q.pol;
            SEL_EDGE: rd_pins = c_q.edg;
            SEL_FILT: rd_pins = c_q.filt;
            SEL_BOTH: rd_pins = c_q.both;
            default:  rd_pins = '0;
        endcase
        bus_rdata = '0;
        if (bus_sel) bus_rdata[NPINS-1:0] = rd_pins;
    end

    assign pin_out = c_q.dout;
    assign pin_oe  = c_q.dir & ~c_q.mode;

    // R2: a config write is visible in the register next cycle
    p_cfg_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_POL) |=> (c_q.pol == $past(wpins)));

    // R3: pins switched to interrupt input release their driver
    p_oe_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_MODE) |=> ((pin_oe & $past(wpins)) == '0));

    // R11: the request never rises without a status source
    p_irq_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> ((stat & en) != '0));

endmodule

// File: tb/tb_gpio_irq_bank.sv
module tb_gpio_irq_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pins = '0;
    logic [31:0] pin_out, pin_oe;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model
    logic [31:0] m_mode, m_dir, m_pol, m_edg, m_both, m_stat, m_en;

    always #2 clk = ~clk;

    gpio_irq_bank #(.NPINS(32)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pins), .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 0;
    endtask

    function automatic logic [31:0] lvl_part(input logic [31:0] v);
        return m_mode & ~m_edg & (v ^ m_pol);
    endfunction

    task automatic apply_vec(input logic [31:0] v);
        logic [31:0] r, f, ev;
        r  = v & ~pins;
        f  = ~v & pins;
        ev = m_mode & m_edg & ((m_both & (r | f)) | (~m_both & ~m_pol & r) | (~m_both & m_pol & f));
        @(negedge clk);
        pins = v;
        repeat (4) @(negedge clk);
        m_stat = ((m_stat | ev) & m_mode & m_edg) | lvl_part(v);
    endtask

    task automatic check_stat(input string tag);
        logic [31:0] d;
        rd(8'h10, d);
        chk(tag, d, m_stat);
        chk({tag, " R11 irq"}, {31'b0, irq_out}, {31'b0, |(m_stat & m_en)});
    endtask

    initial begin
        logic [31:0] d, lfsr;
        m_stat = '0; m_en = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset state
        foreach (d[i]) ;
        for (int a = 0; a < 8'h50; a += 4) begin
            rd(a[7:0], d);
            chk("R1 reset register", d, 32'h0);
        end
        chk("R1 pin_oe", pin_oe, 32'h0);
        chk("R1 pin_out", pin_out, 32'h0);
        chk("R1 irq_out", {31'b0, irq_out}, 32'h0);

        // R2: readback of each config register
        wr(8'h00, 32'h1234_5678); rd(8'h00, d); chk("R2 mode", d, 32'h1234_5678);
        wr(8'h04, 32'h9ABC_DEF0); rd(8'h04, d); chk("R2 dir", d, 32'h9ABC_DEF0);
        wr(8'h08, 32'hA5A5_3C3C); rd(8'h08, d); chk("R2 dout", d, 32'hA5A5_3C3C);
        wr(8'h20, 32'h0F0F_F0F0); rd(8'h20, d); chk("R2 pol", d, 32'h0F0F_F0F0);
        wr(8'h24, 32'h3333_CCCC); rd(8'h24, d); chk("R2 edge", d, 32'h3333_CCCC);
        wr(8'h28, 32'hDEAD_BEEF); rd(8'h28, d); chk("R2 filt", d, 32'hDEAD_BEEF);
        wr(8'h4C, 32'h5555_AAAA); rd(8'h4C, d); chk("R2 both", d, 32'h5555_AAAA);
        rd(8'h14, d); chk("R2 clear reads 0", d, 32'h0);
        rd(8'h1C, d); chk("R2 unmask reads 0", d, 32'h0);
        wr(8'h40, 32'hFFFF_FFFF); rd(8'h40, d); chk("R2 unmapped", d, 32'h0);

        // R3: output drive
        wr(8'h00, 32'hFF00_FF00); wr(8'h04, 32'hF0F0_F0F0);
        chk("R3 pin_oe", pin_oe, 32'hF0F0_F0F0 & ~32'hFF00_FF00);
        chk("R3 pin_out", pin_out, 32'hA5A5_3C3C);

        // sweep configuration: pins 0..7 general, others interrupt
        wr(8'h28, 32'h0);
        wr(8'h00, 32'h0);
        for (int i = 0; i < 32; i++) begin
            m_mode[i] = (i >= 8);
            m_pol[i]  = i[0];
            m_edg[i]  = i[1];
            m_both[i] = i[2];
        end
        m_dir = 32'h0F0F_0F0F;
        wr(8'h20, m_pol); wr(8'h24, m_edg); wr(8'h4C, m_both);
        wr(8'h04, m_dir); wr(8'h00, m_mode);
        chk("R3 pin_oe in mixed modes", pin_oe, m_dir & ~m_mode);
        wr(8'h14, 32'hFFFF_FFFF);
        repeat (4) @(negedge clk);
        m_stat = lvl_part(pins);
        wr(8'h1C, 32'hFFFF_FFFF);
        m_en = 32'hFFFF_FFFF;
        check_stat("R6 R7 initial status");

        // R4: synchroniser latency
        @(negedge clk); pins = 32'h0000_00F0;
        @(negedge clk); bus_sel = 1; bus_addr = 8'h0C; #1 d = bus_rdata; bus_sel = 0;
        chk("R4 din after one edge", d, 32'h0);
        @(negedge clk); bus_sel = 1; bus_addr = 8'h0C; #1 d = bus_rdata; bus_sel = 0;
        chk("R4 din after two edges", d, 32'h0000_00F0);
        repeat (3) @(negedge clk);
        m_stat = (m_stat & m_mode & m_edg) | lvl_part(pins);
        check_stat("R7 general pins toggled");

        // R5/R6/R7: vector sweep
        apply_vec(32'h0);              check_stat("R5 R6 zero");
        apply_vec(32'hFFFF_FFFF);      check_stat("R5 R6 all high");
        wr(8'h14, 32'hFFFF_FFFF); m_stat = lvl_part(pins); check_stat("R8 clear all");
        apply_vec(32'h0);              check_stat("R5 R6 fall all");
        wr(8'h14, 32'hFFFF_FFFF); m_stat = lvl_part(pins);
        apply_vec(32'h5555_5555);      check_stat("R5 R6 alternating 5");
        apply_vec(32'hAAAA_AAAA);      check_stat("R5 R6 alternating A");
        lfsr = 32'hC0FF_EE01;
        for (int k = 0; k < 24; k++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            apply_vec(lfsr);
            check_stat("R5 R6 R7 random vector");
            rd(8'h0C, d); chk("R4 din random", d, lfsr);
            if (k % 6 == 5) begin
                wr(8'h14, 32'hFFFF_FFFF);
                m_stat = lvl_part(pins);
            end
        end

        // R8: partial clear
        apply_vec(32'h0); apply_vec(32'hFFFF_FFFF); apply_vec(32'h0);
        check_stat("R5 latched all edges");
        wr(8'h14, 32'h0000_FFFF);
        m_stat = (m_stat & ~(32'h0000_FFFF & m_mode & m_edg));
        check_stat("R8 partial clear");
        wr(8'h14, 32'h0);
        check_stat("R8 zero write no effect");

        // R9: clear collides with new rising edge on pin 10
        wr(8'h14, 32'hFFFF_FFFF); m_stat = lvl_part(pins);
        @(negedge clk); pins[10] = 1'b1;
        @(posedge clk); @(posedge clk);
        wr(8'h14, 32'h0000_0400);
        repeat (3) @(negedge clk);
        rd(8'h10, d);
        chk("R9 event wins over clear", d & 32'h0000_0400, 32'h0000_0400);
        wr(8'h14, 32'h0000_0400);
        rd(8'h10, d);
        chk("R8 clear without event", d & 32'h0000_0400, 32'h0);

        // R10/R11: mask handling
        wr(8'h14, 32'hFFFF_FFFF);
        apply_vec(32'h0);
        m_stat = lvl_part(32'h0);
        wr(8'h14, 32'hFFFF_FFFF);
        m_stat = lvl_part(32'h0);
        wr(8'h18, 32'h0);  m_en = 0;
        rd(8'h18, d); chk("R10 mask all", d, 32'h0);
        chk("R11 irq low when all masked", {31'b0, irq_out}, 32'h0);
        wr(8'h1C, 32'h0000_0400); m_en = 32'h0000_0400;
        rd(8'h18, d); chk("R10 unmask one", d, 32'h0000_0400);
        chk("R11 irq low with no status", {31'b0, irq_out}, 32'h0);
        apply_vec(32'h0000_0400);
        check_stat("R11 irq from pin 10");
        wr(8'h1C, 32'hFFFF_FFFF); m_en = 32'hFFFF_FFFF;
        wr(8'h18, 32'hFFFF_FBFF); m_en = 32'hFFFF_FBFF;
        rd(8'h18, d); chk("R10 mask keeps ones", d, 32'hFFFF_FBFF);
        check_stat("R11 irq follows enables");

        // R12: filter register has no effect
        wr(8'h28, 32'hFFFF_FFFF);
        apply_vec(32'h3C3C_C3C3); check_stat("R12 filter on vector 1");
        apply_vec(32'hC3C3_3C3C); check_stat("R12 filter on vector 2");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule